// File: doc/BRIEF.md
# Low-Rate Encode Clock Detector with Fallback Enable

This block watches an encode clock from a free-running reference clock. It decides whether the encode rate has dropped below a set level, and in that case it turns on the enable for a fallback oscillator. Encode edges are counted in the encode domain. At regular intervals of `WIN_CYC` reference cycles, the reference side asks for the count with a toggle, and the encode side hands back a stable snapshot with a toggle of its own. The reference side compares each snapshot against a low threshold and a higher release level. The gap between the two gives hysteresis.

If a request is still unanswered when the next interval ends, the encode clock is taken to be stopped, and that counts as a low rate. Software-style control comes in on two plain inputs. The detect enable is normally held high; when it is low, the low-rate flag is held at zero. The run input forces the fallback enable on at any encode rate, including a stopped clock. The fallback enable is a register loaded with `run OR (detect_enable AND low_rate)`, so it is free of glitches.

Top module: `lrm_top`

## Requirements
- R1: While `rst` is high, and on the first reference edge after it is sampled high, both `low_rate` and `fb_osc_en` are 0.
- R2: With `det_en` high, an interval count below `THRESH` (default 12 edges per 256 reference cycles) sets `low_rate` to 1 one reference cycle after the measurement arrives.
- R3: Once set, `low_rate` returns to 0 only after an interval count greater than `THRESH + HYST` (default 14), or when `det_en` is low.
- R4: An interval count from `THRESH` to `THRESH + HYST` inclusive leaves `low_rate` unchanged, whether it was set or clear.
- R5: If the encode side has not answered a count request by the end of the next interval, the clock is treated as stopped and `low_rate` becomes 1 (with `det_en` high).
- R6: When `det_en` is 0, `low_rate` is 0 from the next reference edge on, at any encode rate.
- R7: `fb_osc_en` equals `force_run OR (det_en AND low_rate)` as sampled one reference cycle earlier.
- R8: With `force_run` high, `fb_osc_en` is 1 from the next reference edge on, at any encode rate and any `det_en` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| clk_enc | input | 1 | Encode clock under measurement |
| det_en | input | 1 | Detector enable (normally 1) |
| force_run | input | 1 | Forces the fallback enable on (normally 0) |
| fb_osc_en | output | 1 | Registered fallback oscillator enable |
| low_rate | output | 1 | Low-rate status flag |

## Verification
Several rules are checked by assertions on every reference cycle. These are the output-enable law, the effect of force, the clearing of the flag by the detector enable, and the rule that the flag only rises after a low count or a stall and only falls after a count above the release level. How a given encode period turns into an interval count is shown only by the bench's scenarios. These scenarios cover fast, slow, near-threshold and stopped clocks, and the band inside the hysteresis gap approached from both sides. The scenarios also show the recovery of the handshake after a stall and after a reset in the middle of a run.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  // Outcome of one decision step on the low-rate flag.
  typedef enum logic [1:0] {
    JUDGE_HOLD  = 2'd0,
    JUDGE_SET   = 2'd1,
    JUDGE_CLEAR = 2'd2
  } judge_e;

  // Bits needed to hold values 0..n.
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lrm_sync.sv
// Multi-stage bit synchronizer with synchronous reset in the destination domain.
module lrm_sync #(
  parameter int unsigned        WIDTH   = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lrm_enc_count.sv
// Encode-domain edge counter; snapshots and restarts on each request toggle.
module lrm_enc_count #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_enc,
  input  logic             rst,       // reference-domain reset, synchronized here
  input  logic             req_tgl,   // reference-domain request toggle
  output logic [CNT_W-1:0] snap_cnt,
  output logic             ack_tgl
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_enc;
  logic                   req_s;
  logic                   req_q;
  logic [CNT_W-1:0]       edge_cnt;

  always_ff @(posedge clk_enc) begin
    rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], rst};
  end
  assign rst_enc = rst_pipe[SYNC_STAGES-1];

  lrm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk (clk_enc),
    .rst (rst_enc),
    .d   (req_tgl),
    .q   (req_s)
  );

  always_ff @(posedge clk_enc) begin
    if (rst_enc) begin
      edge_cnt <= '0;
      snap_cnt <= '0;
      ack_tgl  <= 1'b0;
      req_q    <= 1'b0;
    end else if (req_s != req_q) begin
      req_q    <= req_s;
      snap_cnt <= edge_cnt;
      edge_cnt <= CNT_W'(1);
      ack_tgl  <= ~ack_tgl;
    end else if (edge_cnt != '1) begin
      edge_cnt <= edge_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lrm_window.sv
// Reference-domain interval timer, request/acknowledge handshake and stall detection.
module lrm_window #(
  parameter int unsigned WIN_CYC     = 256,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic [CNT_W-1:0] snap_cnt,
  input  logic             ack_tgl,
  output logic             req_tgl,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_cnt,
  output logic             stall
);

  localparam int unsigned WIN_W = lrm_pkg::bits_for(WIN_CYC - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0] win_cnt;
  logic             win_end;
  logic             ack_s;
  logic             ack_q;
  logic             ack_edge;
  logic             pending;

  lrm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk (clk_ref),
    .rst (rst),
    .d   (ack_tgl),
    .q   (ack_s)
  );

  assign win_end  = (win_cnt == WIN_LAST);
  assign ack_edge = (ack_s != ack_q);

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      win_cnt    <= '0;
      req_tgl    <= 1'b0;
      ack_q      <= 1'b0;
      pending    <= 1'b0;
      meas_valid <= 1'b0;
      meas_cnt   <= '0;
      stall      <= 1'b0;
    end else begin
      win_cnt    <= win_end ? '0 : win_cnt + 1'b1;
      meas_valid <= 1'b0;
      stall      <= 1'b0;
      if (ack_edge) begin
        ack_q      <= ack_s;
        pending    <= 1'b0;
        meas_cnt   <= snap_cnt;   // snapshot held stable since before the ack toggle
        meas_valid <= 1'b1;
      end
      if (win_end) begin
        if (pending && !ack_edge) begin
          stall <= 1'b1;          // no answer within a full interval: clock stopped
        end else begin
          req_tgl <= ~req_tgl;
          pending <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lrm_judge.sv
// Threshold compare with hysteresis; holds the low-rate flag.
module lrm_judge #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned THRESH = 12,
  parameter int unsigned HYST   = 2
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             det_en,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas_cnt,
  input  logic             stall,
  output logic             low_q
);

  import lrm_pkg::*;

  localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CLR_LIM = CNT_W'(THRESH + HYST);

  judge_e dec;

  always_comb begin
    dec = JUDGE_HOLD;
    if (stall) begin
      dec = JUDGE_SET;
    end else if (meas_valid) begin
      if (meas_cnt < SET_LIM)      dec = JUDGE_SET;
      else if (meas_cnt > CLR_LIM) dec = JUDGE_CLEAR;
    end
  end

  always_ff @(posedge clk_ref) begin
    if (rst || !det_en) begin
      low_q <= 1'b0;
    end else begin
      case (dec)
        JUDGE_SET:   low_q <= 1'b1;
        JUDGE_CLEAR: low_q <= 1'b0;
        default:     low_q <= low_q;
      endcase
    end
  end

endmodule

// File: rtl/lrm_top.sv
module lrm_top #(
  parameter int unsigned WIN_CYC     = 256,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned THRESH      = 12,
  parameter int unsigned HYST        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic clk_enc,
  input  logic det_en,
  input  logic force_run,
  output logic fb_osc_en,
  output logic low_rate
);

  logic             req_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] snap_cnt;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_cnt;
  logic             stall;
  logic             low_q;

  lrm_enc_count #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_enc (
    .clk_enc  (clk_enc),
    .rst      (rst),
    .req_tgl  (req_tgl),
    .snap_cnt (snap_cnt),
    .ack_tgl  (ack_tgl)
  );

  lrm_window #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_win (
    .clk_ref    (clk_ref),
    .rst        (rst),
    .snap_cnt   (snap_cnt),
    .ack_tgl    (ack_tgl),
    .req_tgl    (req_tgl),
    .meas_valid (meas_valid),
    .meas_cnt   (meas_cnt),
    .stall      (stall)
  );

  lrm_judge #(.CNT_W(CNT_W), .THRESH(THRESH), .HYST(HYST)) u_judge (
    .clk_ref    (clk_ref),
    .rst        (rst),
    .det_en     (det_en),
    .meas_valid (meas_valid),
    .meas_cnt   (meas_cnt),
    .stall      (stall),
    .low_q      (low_q)
  );

  // Registered fallback enable: override OR qualified detector result.
  always_ff @(posedge clk_ref) begin
    if (rst) fb_osc_en <= 1'b0;
    else     fb_osc_en <= force_run | (det_en & low_q);
  end

  assign low_rate = low_q;

endmodule

// File: rtl/lrm_top_chk.sv
module lrm_top_chk #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned THRESH = 12,
  parameter int unsigned HYST   = 2
) (
  input logic             clk_ref,
  input logic             rst,
  input logic             det_en,
  input logic             force_run,
  input logic             fb_osc_en,
  input logic             low_rate,
  input logic             meas_valid,
  input logic [CNT_W-1:0] meas_cnt,
  input logic             stall
);

  localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CLR_LIM = CNT_W'(THRESH + HYST);

  p_reset_clear_r1: assert property (@(posedge clk_ref)
    rst |=> (!low_rate && !fb_osc_en));

  p_set_cause_r2: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(low_rate) |-> $past(det_en && (stall || (meas_valid && meas_cnt < SET_LIM))));

  p_clear_cause_r3: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(low_rate) |-> $past(!det_en || (meas_valid && !stall && meas_cnt > CLR_LIM)));

  p_hold_band_r4: assert property (@(posedge clk_ref) disable iff (rst)
    (det_en && meas_valid && !stall && meas_cnt >= SET_LIM && meas_cnt <= CLR_LIM)
      |=> (low_rate == $past(low_rate)));

  p_stall_sets_r5: assert property (@(posedge clk_ref) disable iff (rst)
    (det_en && stall) |=> low_rate);

  p_det_off_r6: assert property (@(posedge clk_ref) disable iff (rst)
    !det_en |=> !low_rate);

  p_low_drives_fb_r7: assert property (@(posedge clk_ref) disable iff (rst)
    (det_en && low_rate) |=> fb_osc_en);

  p_fb_needs_cause_r7: assert property (@(posedge clk_ref) disable iff (rst)
    fb_osc_en |-> $past(force_run || (det_en && low_rate)));

  p_force_on_r8: assert property (@(posedge clk_ref) disable iff (rst)
    force_run |=> fb_osc_en);

endmodule

bind lrm_top lrm_top_chk #(.CNT_W(CNT_W), .THRESH(THRESH), .HYST(HYST)) u_chk (
  .clk_ref    (clk_ref),
  .rst        (rst),
  .det_en     (det_en),
  .force_run  (force_run),
  .fb_osc_en  (fb_osc_en),
  .low_rate   (low_rate),
  .meas_valid (meas_valid),
  .meas_cnt   (meas_cnt),
  .stall      (stall)
);

// File: tb/lrm_top_tb.sv
`timescale 1ns/1ps
module lrm_top_tb;

  localparam int CLK_PERIOD = 10;          // reference clock, ns
  localparam int WIN        = 256;         // reference cycles per interval
  localparam int SETTLE     = 6 * WIN;     // cycles allowed for a new rate to settle

  typedef struct packed {
    logic [15:0] half_ns;  // encode half period
    logic        en;
    logic        frc;
    logic        exp_low;
    logic        exp_fb;
  } vec_t;

  // Sequential: each row starts from the state left by the row above.
  // Interval 2560 ns: half 12 -> ~106 edges, 250 -> 5, 98 -> 13, 120 -> 10.
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{16'd12,  1'b1, 1'b0, 1'b0, 1'b0},  // R2 fast clock stays clear
    '{16'd250, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 slow clock sets flag, R7 fb follows
    '{16'd98,  1'b1, 1'b0, 1'b1, 1'b1},  // R4 band count keeps flag set
    '{16'd12,  1'b1, 1'b0, 1'b0, 1'b0},  // R3 count above release clears
    '{16'd98,  1'b1, 1'b0, 1'b0, 1'b0},  // R4 band count keeps flag clear
    '{16'd120, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 just under threshold sets
    '{16'd250, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 detector off at slow rate
    '{16'd250, 1'b0, 1'b1, 1'b0, 1'b1},  // R8 force with detector off
    '{16'd12,  1'b1, 1'b1, 1'b0, 1'b1},  // R8 force at fast rate
    '{16'd250, 1'b1, 1'b1, 1'b1, 1'b1},  // R7 force and low together
    '{16'd12,  1'b1, 1'b0, 1'b0, 1'b0}   // R3 recovery to fast
  };

  logic clk_ref = 1'b0;
  logic clk_enc = 1'b0;
  logic rst;
  logic det_en;
  logic force_run;
  logic fb_osc_en;
  logic low_rate;

  int enc_half = 12;
  bit enc_run  = 1'b1;
  int n_checks = 0;
  int n_errors = 0;

  lrm_top u_dut (
    .clk_ref   (clk_ref),
    .rst       (rst),
    .clk_enc   (clk_enc),
    .det_en    (det_en),
    .force_run (force_run),
    .fb_osc_en (fb_osc_en),
    .low_rate  (low_rate)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  initial begin
    forever begin
      if (enc_run) #(enc_half) clk_enc = ~clk_enc;
      else         #(CLK_PERIOD);
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  initial begin
    repeat (150000) @(posedge clk_ref);
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst       = 1'b1;
    det_en    = 1'b1;
    force_run = 1'b0;
    wait_ref(20);
    check("R1 low_rate in reset", low_rate, 1'b0);
    check("R1 fb_osc_en in reset", fb_osc_en, 1'b0);
    rst = 1'b0;
    wait_ref(1);
    check("R1 fb_osc_en after reset", fb_osc_en, 1'b0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      enc_half  = int'(VECS[i].half_ns);
      det_en    = VECS[i].en;
      force_run = VECS[i].frc;
      wait_ref(SETTLE);
      check($sformatf("row %0d low_rate", i), low_rate, VECS[i].exp_low);
      check($sformatf("row %0d fb_osc_en", i), fb_osc_en, VECS[i].exp_fb);
    end

    // R8 / R7: one-cycle response to force at a fast rate
    check("R7 fb idle before force", fb_osc_en, 1'b0);
    force_run = 1'b1;
    wait_ref(1);
    check("R8 force one cycle", fb_osc_en, 1'b1);
    force_run = 1'b0;
    wait_ref(1);
    check("R7 fb drops one cycle after force", fb_osc_en, 1'b0);

    // R6: detector off clears flag on the next edge
    enc_half = 250;
    wait_ref(SETTLE);
    check("R2 slow before disable", low_rate, 1'b1);
    det_en = 1'b0;
    wait_ref(1);
    check("R6 flag cleared in one cycle", low_rate, 1'b0);
    check("R7 fb cleared in one cycle", fb_osc_en, 1'b0);
    wait_ref(3 * WIN);
    check("R6 flag stays clear", low_rate, 1'b0);
    det_en = 1'b1;

    // R5: stopped encode clock
    enc_half = 12;
    wait_ref(SETTLE);
    check("R3 fast before stop", low_rate, 1'b0);
    enc_run = 1'b0;
    wait_ref(3 * WIN);
    check("R5 stopped clock low_rate", low_rate, 1'b1);
    check("R5 stopped clock fb_osc_en", fb_osc_en, 1'b1);
    enc_run = 1'b1;
    wait_ref(SETTLE);
    check("R3 recovered after stop", low_rate, 1'b0);

    // R1: reset while flag set, encode clock slow but running
    enc_half = 250;
    wait_ref(SETTLE);
    check("R2 slow before mid reset", low_rate, 1'b1);
    rst = 1'b1;
    wait_ref(1);
    check("R1 low_rate after reset edge", low_rate, 1'b0);
    check("R1 fb_osc_en after reset edge", fb_osc_en, 1'b0);
    wait_ref(300);
    rst = 1'b0;
    enc_half = 12;
    wait_ref(SETTLE);
    check("R3 clear after reset fast", low_rate, 1'b0);
    check("R7 fb clear after reset fast", fb_osc_en, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule